// File: doc/BRIEF.md
# FIFO Port Width Adapter

This block sits between a queue's 40-bit storage word and its external ports and handles ports narrower than a storage word. Five width pairings are allowed: full width on both sides, or a half-width (20-bit) or quarter-width (10-bit) port on exactly one side with full width on the other. A narrow write side collects two or four narrow words into one storage word before that word goes to memory. A narrow read side takes one storage word from memory and hands it out in two or four narrow pieces on successive port reads.

Three static strap inputs select the pairing. The block samples them once, on the first clock edge after reset is released. All four edges use a valid/ready handshake: one pair on the write port, one on the memory write path, one on the memory read path and one on the read port. A separate enable sets the read data bus to high impedance. The reset input is assumed to be already synchronised to the clock.

Top module: `fwm_width_matcher`

## Requirements
- R1: The straps `cfg_split_en`, `cfg_in_narrow` and `cfg_quarter` are sampled on the first rising edge after `rst_n` goes high. During the cycle before that edge, `in_ready` and `mem_rd_ready` are 0. A later change on the straps has no effect until the next reset.
- R2: With `cfg_split_en`=0 (40 to 40), each accepted port write is offered to memory unchanged as one word, and each memory word is returned unchanged by one port read.
- R3: A narrow write side is selected by `cfg_split_en`=1 and `cfg_in_narrow`=1, with 20-bit lanes when `cfg_quarter`=0 and 10-bit lanes when it is 1. The first accepted narrow word fills bits of lane 0 (least significant), and later ones fill higher lanes in order. `mem_wr_valid` rises only once all 2 or 4 lanes are filled.
- R4: When the write side is narrow, `in_data` bits above the lane width are ignored.
- R5: A narrow read side is selected by `cfg_split_en`=1 and `cfg_in_narrow`=0, with the same lane widths. Each memory word is returned over 2 or 4 port reads from lane 0 upward, with bits above the lane width driven as 0. `out_valid` is high exactly while lanes of a fetched word remain.
- R6: A new memory word is accepted (`mem_rd_ready`=1) only when no lanes are pending, or when the last pending lane is taken in the same cycle.
- R7: With `out_oe`=0 the `out_data` bus is released to high impedance. The read handshake and lane sequence do not change.
- R8: Reset clears all state: no word is offered to memory, no port read is valid, and a partly packed word is discarded.
- R9: While `mem_wr_valid` is 1 and `mem_wr_ready` is 0, `mem_wr_valid` stays 1 and `mem_wr_data` is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_split_en | input | 1 | Strap: 0 for equal widths, 1 for one narrow side |
| cfg_in_narrow | input | 1 | Strap: 1 for a narrow write side, 0 for a narrow read side |
| cfg_quarter | input | 1 | Strap: 1 for 10-bit lanes, 0 for 20-bit lanes |
| in_valid | input | 1 | Write port data valid |
| in_ready | output | 1 | Write port can accept |
| in_data | input | 40 | Write port data, low bits used when narrow |
| mem_wr_valid | output | 1 | Full word offered to memory |
| mem_wr_ready | input | 1 | Memory accepts the word |
| mem_wr_data | output | 40 | Word to memory |
| mem_rd_valid | input | 1 | Memory offers a word |
| mem_rd_ready | output | 1 | Block takes the memory word |
| mem_rd_data | input | 40 | Word from memory |
| out_valid | output | 1 | Read port data valid |
| out_ready | input | 1 | Read port consumer takes the data |
| out_oe | input | 1 | Read data bus enable |
| out_data | output | 40 | Read port data, high impedance when disabled |

## Verification
A lane counter that is off by one shows at the memory side on the first packed word. Lanes land shifted, or a word is offered after the wrong number of writes. On the read side it shows on the next port read as a wrong slice, and `mem_rd_ready` opens a cycle early or late. Straps captured at the wrong time give a wrong pairing on the first transfer after reset. A partial word that survives reset corrupts the first word offered after it. The reference model therefore compares every handshake and every transferred value in the cycle it happens.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

  typedef enum logic [1:0] {
    LN_1 = 2'd0,
    LN_2 = 2'd1,
    LN_4 = 2'd2
  } lanes_e;

  function automatic logic [2:0] lane_count(lanes_e l);
    case (l)
      LN_2:    lane_count = 3'd2;
      LN_4:    lane_count = 3'd4;
      default: lane_count = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/fwm_cfg.sv
module fwm_cfg
  import fwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cfg_split_en,
  input  logic   cfg_in_narrow,
  input  logic   cfg_quarter,
  output logic   pend,
  output lanes_e in_lanes,
  output lanes_e out_lanes
);

  lanes_e narrow_sel;
  lanes_e in_d, out_d;

  always_comb begin
    narrow_sel = cfg_quarter ? LN_4 : LN_2;
    in_d       = (cfg_split_en && cfg_in_narrow)  ? narrow_sel : LN_1;
    out_d      = (cfg_split_en && !cfg_in_narrow) ? narrow_sel : LN_1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b1;
      in_lanes  <= LN_1;
      out_lanes <= LN_1;
    end else if (pend) begin
      pend      <= 1'b0;
      in_lanes  <= in_d;
      out_lanes <= out_d;
    end
  end

endmodule

// File: rtl/fwm_packer.sv
module fwm_packer
  import fwm_pkg::*;
#(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  lanes_e       lanes,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         mem_wr_valid,
  input  logic         mem_wr_ready,
  output logic [W-1:0] mem_wr_data
);

  localparam int unsigned SHW = $clog2(W) + 2;
  localparam logic [SHW-1:0] HALF_W = SHW'(W / 2);
  localparam logic [SHW-1:0] QTR_W  = SHW'(W / 4);

  logic [W-1:0]   acc_q, acc_d, base_acc, lane_mask;
  logic [1:0]     cnt_q, cnt_d, base_cnt;
  logic           full_q, full_d;
  logic           drain, take, ce;
  logic [SHW-1:0] lane_w, sh;
  logic [2:0]     n_lanes;

  always_comb begin
    n_lanes   = lane_count(lanes);
    lane_w    = (lanes == LN_4) ? QTR_W : HALF_W;
    lane_mask = (lanes == LN_4) ? ({W{1'b1}} >> (W - W / 4)) :
                (lanes == LN_2) ? ({W{1'b1}} >> (W - W / 2)) : {W{1'b1}};
    drain     = full_q && mem_wr_ready;
    in_ready  = !hold && (!full_q || mem_wr_ready);
    take      = in_valid && in_ready;
    base_acc  = drain ? '0 : acc_q;
    base_cnt  = drain ? 2'd0 : cnt_q;
    sh        = SHW'(base_cnt) * lane_w;
    acc_d     = base_acc;
    cnt_d     = base_cnt;
    full_d    = full_q && !mem_wr_ready;
    if (take) begin
      acc_d = base_acc | ((in_data & lane_mask) << sh);
      if (({1'b0, base_cnt} + 3'd1) == n_lanes) begin
        full_d = 1'b1;
        cnt_d  = 2'd0;
      end else begin
        cnt_d = base_cnt + 2'd1;
      end
    end
    ce = drain || take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= 2'd0;
      full_q <= 1'b0;
    end else if (ce) begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign mem_wr_valid = full_q;
  assign mem_wr_data  = acc_q;

endmodule

// File: rtl/fwm_unpacker.sv
module fwm_unpacker
  import fwm_pkg::*;
#(
  parameter int unsigned W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  lanes_e       lanes,
  input  logic         mem_rd_valid,
  output logic         mem_rd_ready,
  input  logic [W-1:0] mem_rd_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);

  localparam int unsigned SHW = $clog2(W) + 2;
  localparam logic [SHW-1:0] HALF_W = SHW'(W / 2);
  localparam logic [SHW-1:0] QTR_W  = SHW'(W / 4);

  logic [W-1:0]   word_q, word_d, lane_mask;
  logic [1:0]     idx_q, idx_d;
  logic           have_q, have_d;
  logic           last, pop, load, ce;
  logic [SHW-1:0] lane_w, sh;

  always_comb begin
    lane_w    = (lanes == LN_4) ? QTR_W : HALF_W;
    lane_mask = (lanes == LN_4) ? ({W{1'b1}} >> (W - W / 4)) :
                (lanes == LN_2) ? ({W{1'b1}} >> (W - W / 2)) : {W{1'b1}};
    last         = ({1'b0, idx_q} + 3'd1) == lane_count(lanes);
    pop          = have_q && out_ready;
    mem_rd_ready = !hold && (!have_q || (pop && last));
    load         = mem_rd_valid && mem_rd_ready;
    word_d       = word_q;
    have_d       = have_q;
    idx_d        = idx_q;
    if (load) begin
      word_d = mem_rd_data;
      have_d = 1'b1;
      idx_d  = 2'd0;
    end else if (pop) begin
      if (last) begin
        have_d = 1'b0;
        idx_d  = 2'd0;
      end else begin
        idx_d = idx_q + 2'd1;
      end
    end
    ce = load || pop;
    sh = SHW'(idx_q) * lane_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= 2'd0;
      have_q <= 1'b0;
    end else if (ce) begin
      word_q <= word_d;
      idx_q  <= idx_d;
      have_q <= have_d;
    end
  end

  assign out_valid = have_q;
  assign out_word  = (word_q >> sh) & lane_mask;

endmodule

// File: rtl/fwm_width_matcher.sv
module fwm_width_matcher
  import fwm_pkg::*;
#(
  parameter int unsigned WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_split_en,
  input  logic              cfg_in_narrow,
  input  logic              cfg_quarter,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic              mem_rd_valid,
  output logic              mem_rd_ready,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              out_oe,
  output logic [WORD_W-1:0] out_data
);

  logic              cfg_pend;
  lanes_e            in_lanes, out_lanes;
  logic [WORD_W-1:0] out_word;

  fwm_cfg u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_split_en  (cfg_split_en),
    .cfg_in_narrow (cfg_in_narrow),
    .cfg_quarter   (cfg_quarter),
    .pend          (cfg_pend),
    .in_lanes      (in_lanes),
    .out_lanes     (out_lanes)
  );

  fwm_packer #(.W(WORD_W)) u_pack (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold         (cfg_pend),
    .lanes        (in_lanes),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_data  (mem_wr_data)
  );

  fwm_unpacker #(.W(WORD_W)) u_unpack (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold         (cfg_pend),
    .lanes        (out_lanes),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_data  (mem_rd_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_word     (out_word)
  );

  assign out_data = out_oe ? out_word : {WORD_W{1'bz}};

endmodule

// File: rtl/fwm_width_matcher_chk.sv
module fwm_width_matcher_chk
  import fwm_pkg::*;
#(
  parameter int unsigned WORD_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_pend,
  input lanes_e            in_lanes,
  input lanes_e            out_lanes,
  input logic              in_ready,
  input logic              mem_rd_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [WORD_W-1:0] mem_wr_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word
);

  AST_INIT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pend |-> (!in_ready && !mem_rd_ready)); // R1

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pend |=> ($stable(in_lanes) && $stable(out_lanes))); // R1

  AST_ONE_SIDE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pend |-> (in_lanes == LN_1 || out_lanes == LN_1)); // R3

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_data))); // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R5

  AST_QTR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_lanes == LN_4) |-> (out_word[WORD_W-1:WORD_W/4] == '0)); // R5

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_lanes == LN_2) |-> (out_word[WORD_W-1:WORD_W/2] == '0)); // R5

endmodule

bind fwm_width_matcher fwm_width_matcher_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_pend     (cfg_pend),
  .in_lanes     (in_lanes),
  .out_lanes    (out_lanes),
  .in_ready     (in_ready),
  .mem_rd_ready (mem_rd_ready),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_data  (mem_wr_data),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_word     (out_word)
);

// File: tb/fwm_width_matcher_tb.sv
`timescale 1ns/100ps
module fwm_width_matcher_tb;

  localparam int W = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_split_en = 1'b0, cfg_in_narrow = 1'b0, cfg_quarter = 1'b0;
  logic         in_valid = 1'b0, mem_wr_ready = 1'b0, mem_rd_valid = 1'b0;
  logic         out_ready = 1'b0, out_oe = 1'b1;
  logic [W-1:0] in_data = '0, mem_rd_data = '0;
  logic         in_ready, mem_wr_valid, mem_rd_ready, out_valid;
  logic [W-1:0] mem_wr_data;
  wire  [W-1:0] out_data;

  always #2 clk = ~clk;

  fwm_width_matcher #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_split_en(cfg_split_en), .cfg_in_narrow(cfg_in_narrow), .cfg_quarter(cfg_quarter),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_oe(out_oe), .out_data(out_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  int l_in, l_out, m_k, src_idx;
  logic [W-1:0] m_acc;
  logic [W-1:0] exp_wq[$];
  logic [W-1:0] exp_rq[$];
  logic         prev_stall = 1'b0;
  logic [W-1:0] prev_wdata = '0;

  task automatic check(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] src_word(input int i);
    logic [31:0] h = 32'(i) * 32'h9E37_79B9;
    return {8'(i), h};
  endfunction

  function automatic logic [W-1:0] lmask(input int l);
    return {W{1'b1}} >> (W - W / l);
  endfunction

  task automatic do_reset(input logic sp, input logic nin, input logic q);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; mem_rd_valid = 1'b0; mem_wr_ready = 1'b0; out_ready = 1'b0;
    cfg_split_en = sp; cfg_in_narrow = nin; cfg_quarter = q;
    m_k = 0; m_acc = '0; exp_wq.delete(); exp_rq.delete(); prev_stall = 1'b0;
    l_in  = (sp && nin)  ? (q ? 4 : 2) : 1;
    l_out = (sp && !nin) ? (q ? 4 : 2) : 1;
    #1;
    check(!mem_wr_valid && !out_valid, "R8 reset state", {38'd0, mem_wr_valid, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!in_ready && !mem_rd_ready, "R1 closed before strap capture", {38'd0, in_ready, mem_rd_ready}, '0);
  endtask

  task automatic run(input int n, input int p_in, input int p_wr, input int p_rd, input int p_out, input bit scramble);
    for (int c = 0; c < n; c++) begin
      logic exp_rdy;
      @(negedge clk);
      in_valid     = ($urandom_range(99) < p_in);
      in_data      = {$urandom, $urandom};
      mem_wr_ready = ($urandom_range(99) < p_wr);
      mem_rd_valid = ($urandom_range(99) < p_rd);
      mem_rd_data  = src_word(src_idx);
      out_ready    = ($urandom_range(99) < p_out);
      out_oe       = ($urandom_range(99) < 80);
      if (scramble) begin
        cfg_split_en = 1'($urandom); cfg_in_narrow = 1'($urandom); cfg_quarter = 1'($urandom);
      end
      #1;
      // R9 held word under backpressure
      if (prev_stall)
        check(mem_wr_valid && mem_wr_data == prev_wdata, "R9 hold", mem_wr_data, prev_wdata);
      prev_stall = mem_wr_valid && !mem_wr_ready;
      prev_wdata = mem_wr_data;
      // R3: a word is offered exactly when the model has completed one
      check(mem_wr_valid == (exp_wq.size() != 0), "R3 commit timing", W'(mem_wr_valid), W'(exp_wq.size() != 0));
      // R5/R6: read side valid and memory acceptance
      check(out_valid == (exp_rq.size() != 0), "R5 out_valid", W'(out_valid), W'(exp_rq.size() != 0));
      exp_rdy = (exp_rq.size() == 0) || (exp_rq.size() == 1 && out_ready);
      check(mem_rd_ready == exp_rdy, "R6 mem_rd_ready", W'(mem_rd_ready), W'(exp_rdy));
      if (!out_oe)
        check(out_data === {W{1'bz}} || out_data === '0, "R7 bus released", out_data, {W{1'bz}});
      if (mem_wr_valid && mem_wr_ready && exp_wq.size() != 0) begin
        logic [W-1:0] e = exp_wq.pop_front();
        check(mem_wr_data == e, (l_in == 1) ? "R2 word" : "R3 R4 packed word", mem_wr_data, e);
      end
      if (out_valid && out_ready && exp_rq.size() != 0) begin
        logic [W-1:0] e = exp_rq.pop_front();
        if (out_oe) check(out_data === e, (l_out == 1) ? "R2 word" : "R5 lane", out_data, e);
      end
      if (in_valid && in_ready) begin
        m_acc = m_acc | ((in_data & lmask(l_in)) << (m_k * (W / l_in)));
        m_k++;
        if (m_k == l_in) begin
          exp_wq.push_back(m_acc);
          m_acc = '0; m_k = 0;
        end
      end
      if (mem_rd_valid && mem_rd_ready) begin
        for (int k = 0; k < l_out; k++)
          exp_rq.push_back((mem_rd_data >> (k * (W / l_out))) & lmask(l_out));
        src_idx++;
      end
    end
  endtask

  initial begin
    src_idx = 1;
    // R2 symmetric
    do_reset(1'b0, 1'b0, 1'b0);
    run(400, 60, 60, 60, 60, 1'b1);
    // R3 R4 narrow write, half and quarter
    do_reset(1'b1, 1'b1, 1'b0);
    run(400, 70, 50, 50, 70, 1'b1);
    do_reset(1'b1, 1'b1, 1'b1);
    run(400, 80, 40, 50, 70, 1'b1);
    // R5 R6 narrow read, half and quarter
    do_reset(1'b1, 1'b0, 1'b0);
    run(400, 50, 70, 70, 60, 1'b1);
    do_reset(1'b1, 1'b0, 1'b1);
    run(400, 50, 70, 80, 50, 1'b1);
    // R8 reset in mid-word: two quarter lanes taken, then reset
    do_reset(1'b1, 1'b1, 1'b1);
    run(2, 100, 0, 0, 0, 1'b0);
    do_reset(1'b1, 1'b1, 1'b1);
    run(300, 80, 60, 50, 60, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule